// File: doc/BRIEF.md
# Memory Sequence Game Controller

This block runs a repeat-the-pattern memory game on four indicator lamps and four push buttons. The button inputs are already clean single-cycle strobes. A slow `tick` enable from an outside divider sets the lamp timing. The controller keeps the growing pattern and the score in its own storage. Each round it adds one random step to the end of the pattern and plays the whole pattern back on the lamps. It then checks the player's presses against the pattern. Three seven-segment digit codes show whose turn it is and the score in decimal.

The controller is a single state machine. Its states are `ST_IDLE`, `ST_ADD`, `ST_SHOW`, `ST_GAP`, `ST_WAIT`, `ST_OVER`, `ST_WIN`, `ST_TSWEEP` and `ST_TECHO`. The game path runs as follows:
- IDLE→ADD on any press.
- ADD→SHOW after one cycle, when the new step is written.
- SHOW→GAP when the lit time ends.
- GAP→SHOW for the next step, or GAP→WAIT after the last step.
- WAIT→ADD when a round is finished below capacity.
- WAIT→WIN when a round is finished at capacity.
- WAIT→OVER on a wrong press.

The lamp-test path runs from any state to TSWEEP when the test switch is raised, then TSWEEP→TECHO after the fourth lamp. Lowering the switch in either test state goes to IDLE. The reset switch forces IDLE from anywhere.

Top module: `seq_game_ctrl`

## Requirements
- R1: While `rst_sw` is high and in the cycle after it falls, all lamps are off, `seg_turn` is 0x3F (dash), and `seg_tens` and `seg_ones` are 0x40. Reset empties the pattern, so the next game starts with one step.
- R2: In idle, any button strobe starts a game. The next cycle shows the machine-turn code, and one step taken from the two low bits of a free-running 16-bit maximal-length LFSR is appended.
- R3: During playback each step lights exactly one lamp, `lamp[i]` for step value i, for 8 ticks. An all-off gap of 4 ticks follows every step, including the last one. While `tick` is low, playback does not advance.
- R4: In each new round the pattern has exactly one more step than in the last round. The earlier steps keep their values and order, and the whole pattern is played back before entry.
- R5: A press counts only in the entry phase. It is correct when `btn` equals the one-hot code of the next expected step. Presses during playback, including one in the last gap cycle, have no effect.
- R6: In the entry phase, a press that is not the expected one-hot code (a wrong button or several buttons at once) ends the game. The turn code becomes 0x06 ('E'), the lamps go dark, and the score is frozen. Later presses change nothing.
- R7: The score is the number of rounds completed. It goes up at the edge that accepts the last correct press of a round. It is shown as tens and ones digits, active-low in gfedcba order: 0=0x40, 1=0x79, 2=0x24, 3=0x30, 4=0x19, 5=0x12, 6=0x02, 7=0x78, 8=0x00, 9=0x10.
- R8: `seg_turn` shows 0x46 ('C') while the machine adds a step or plays back, and 0x0C ('P') while the player enters.
- R9: Finishing a round with 32 stored steps wins the game. `seg_turn` shows 0x41 ('U'), the score shows 32, and later presses change nothing.
- R10: Raising `test_sw` clears the game. The controller then lights lamp 0, 1, 2 and 3 in turn for 8 ticks each and goes dark. After that, each single-button press lights the matching lamp until the next single press, and multi-button presses are ignored. All three digits show 0x07 ('t') throughout. Lowering `test_sw` returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_sw | input | 1 | Synchronous active-high reset switch |
| test_sw | input | 1 | Lamp self-test switch, active high |
| tick | input | 1 | Timing enable for lamp durations |
| btn | input | 4 | Button strobes, one cycle each, bit i = button i |
| lamp | output | 4 | Indicator lamps, bit i = lamp i |
| seg_turn | output | 7 | Turn / mode digit, active-low gfedcba |
| seg_tens | output | 7 | Score tens digit, active-low gfedcba |
| seg_ones | output | 7 | Score ones digit, active-low gfedcba |

## Verification
Playback and button sampling can fall in the same cycle. A strobe can arrive in the last gap cycle, exactly when the machine hands the turn to the player. The bench counts the gap cycles of the final step and drives a press into the fourth one. It then checks three things: the game is not over, the turn code becomes 'P', and a full correct entry of the round still raises the score by exactly one. A stalled `tick` in the middle of a lit step is also checked: the lamp must hold, and the step must still total eight ticks.

// File: rtl/seq_game_pkg.sv
package seq_game_pkg;

    localparam int NLAMP = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADD,
        ST_SHOW,
        ST_GAP,
        ST_WAIT,
        ST_OVER,
        ST_WIN,
        ST_TSWEEP,
        ST_TECHO
    } game_st_t;

    localparam logic [6:0] SEG_DASH  = 7'h3F;
    localparam logic [6:0] SEG_MACH  = 7'h46;
    localparam logic [6:0] SEG_PLYR  = 7'h0C;
    localparam logic [6:0] SEG_OVER  = 7'h06;
    localparam logic [6:0] SEG_WIN   = 7'h41;
    localparam logic [6:0] SEG_TEST  = 7'h07;
    localparam logic [6:0] SEG_BLANK = 7'h7F;

    // active-low, bit order g f e d c b a
    function automatic logic [6:0] seg_dec(input logic [3:0] d);
        logic [6:0] s;
        unique case (d)
            4'd0: s = 7'h40;
            4'd1: s = 7'h79;
            4'd2: s = 7'h24;
            4'd3: s = 7'h30;
            4'd4: s = 7'h19;
            4'd5: s = 7'h12;
            4'd6: s = 7'h02;
            4'd7: s = 7'h78;
            4'd8: s = 7'h00;
            4'd9: s = 7'h10;
            default: s = SEG_BLANK;
        endcase
        return s;
    endfunction

    function automatic logic [NLAMP-1:0] lamp_hot(input logic [1:0] i);
        return NLAMP'(1) << i;
    endfunction

endpackage

// File: rtl/sg_lfsr.sv
module sg_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst,
    output logic [1:0] step
);
    logic [15:0] sr_q;
    logic        fb;

    // taps 16,14,13,11: maximal length
    assign fb = sr_q[15] ^ sr_q[13] ^ sr_q[12] ^ sr_q[10];

    always_ff @(posedge clk) begin
        if (rst) sr_q <= SEED;
        else     sr_q <= {sr_q[14:0], fb};
    end

    assign step = sr_q[1:0];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        sr_q != 16'h0000); // R2
endmodule

// File: rtl/sg_pattern_mem.sv
module sg_pattern_mem #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [1:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [1:0]    rdata
);
    logic [1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 2'd0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sg_display.sv
module sg_display #(
    parameter int SW = 6
) (
    input  seq_game_pkg::game_st_t st,
    input  logic [SW-1:0]          score,
    output logic [6:0]             seg_turn,
    output logic [6:0]             seg_tens,
    output logic [6:0]             seg_ones
);
    import seq_game_pkg::*;

    logic [3:0] tens, ones;
    assign tens = 4'(score / 10);
    assign ones = 4'(score % 10);

    always_comb begin
        seg_tens = seg_dec(tens);
        seg_ones = seg_dec(ones);
        unique case (st)
            ST_IDLE:                   seg_turn = SEG_DASH;
            ST_ADD, ST_SHOW, ST_GAP:   seg_turn = SEG_MACH;
            ST_WAIT:                   seg_turn = SEG_PLYR;
            ST_OVER:                   seg_turn = SEG_OVER;
            ST_WIN:                    seg_turn = SEG_WIN;
            ST_TSWEEP, ST_TECHO: begin
                seg_turn = SEG_TEST;
                seg_tens = SEG_TEST;
                seg_ones = SEG_TEST;
            end
            default:                   seg_turn = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/seq_game_ctrl.sv
module seq_game_ctrl #(
    parameter int          DEPTH     = 32,
    parameter int          ON_TICKS  = 8,
    parameter int          GAP_TICKS = 4,
    parameter logic [15:0] SEED      = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_sw,
    input  logic       test_sw,
    input  logic       tick,
    input  logic [3:0] btn,
    output logic [3:0] lamp,
    output logic [6:0] seg_turn,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_ones
);
    import seq_game_pkg::*;

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int LEN_W   = $clog2(DEPTH + 1);
    localparam int CNT_MAX = (ON_TICKS > GAP_TICKS) ? ON_TICKS : GAP_TICKS;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

    game_st_t         state_q, state_d;
    logic [LEN_W-1:0] len_q, score_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] tcnt_q;
    logic [3:0]       echo_q;
    logic [1:0]       step_rnd, step_rd;
    logic             is_test, last, on_done, gap_done, press, hit, sweep_last;

    sg_lfsr #(.SEED(SEED)) u_rng (
        .clk (clk), .rst (rst_sw), .step (step_rnd)
    );

    sg_pattern_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst   (rst_sw),
        .we    (state_q == ST_ADD),
        .waddr (len_q[IDX_W-1:0]),
        .wdata (step_rnd),
        .raddr (idx_q),
        .rdata (step_rd)
    );

    sg_display #(.SW(LEN_W)) u_dsp (
        .st (state_q), .score (score_q),
        .seg_turn (seg_turn), .seg_tens (seg_tens), .seg_ones (seg_ones)
    );

    assign is_test    = (state_q == ST_TSWEEP) || (state_q == ST_TECHO);
    assign last       = (LEN_W'(idx_q) == len_q - LEN_W'(1));
    assign on_done    = tick && (tcnt_q == CNT_W'(ON_TICKS - 1));
    assign gap_done   = tick && (tcnt_q == CNT_W'(GAP_TICKS - 1));
    assign press      = |btn;
    assign hit        = (btn == lamp_hot(step_rd));
    assign sweep_last = (idx_q == IDX_W'(NLAMP - 1));

    // next state
    always_comb begin
        state_d = state_q;
        if (test_sw && !is_test) begin
            state_d = ST_TSWEEP;
        end else if (!test_sw && is_test) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (press) state_d = ST_ADD;
                ST_ADD:    state_d = ST_SHOW;
                ST_SHOW:   if (on_done) state_d = ST_GAP;
                ST_GAP:    if (gap_done) state_d = last ? ST_WAIT : ST_SHOW;
                ST_WAIT: begin
                    if (press) begin
                        if (!hit)      state_d = ST_OVER;
                        else if (last) state_d = (len_q == LEN_W'(DEPTH)) ? ST_WIN : ST_ADD;
                    end
                end
                ST_OVER, ST_WIN, ST_TECHO: state_d = state_q;
                ST_TSWEEP: if (on_done && sweep_last) state_d = ST_TECHO;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (rst_sw) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            score_q <= '0;
            idx_q   <= '0;
            tcnt_q  <= '0;
            echo_q  <= '0;
        end else begin
            state_q <= state_d;

            if (state_d != state_q)
                tcnt_q <= '0;
            else if ((state_q == ST_SHOW || state_q == ST_TSWEEP) && on_done)
                tcnt_q <= '0;
            else if ((state_q == ST_SHOW || state_q == ST_GAP || state_q == ST_TSWEEP) && tick)
                tcnt_q <= tcnt_q + CNT_W'(1);

            if (state_q == ST_ADD) begin
                len_q <= len_q + LEN_W'(1);
                idx_q <= '0;
            end
            if (state_q == ST_GAP && gap_done)
                idx_q <= last ? '0 : idx_q + IDX_W'(1);
            if (state_q == ST_WAIT && press && hit) begin
                idx_q <= last ? '0 : idx_q + IDX_W'(1);
                if (last) score_q <= score_q + LEN_W'(1);
            end
            if (state_q == ST_TSWEEP && on_done)
                idx_q <= idx_q + IDX_W'(1);
            if (state_q == ST_TECHO && $onehot(btn))
                echo_q <= btn;
            if (state_d == ST_TSWEEP && state_q != ST_TSWEEP) begin
                idx_q   <= '0;
                echo_q  <= '0;
                len_q   <= '0;
                score_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SHOW:   lamp = lamp_hot(step_rd);
            ST_TSWEEP: lamp = lamp_hot(idx_q[1:0]);
            ST_TECHO:  lamp = echo_q;
            default:   lamp = '0;
        endcase
    end

    AST_SHOW_LAMP: assert property (@(posedge clk) disable iff (rst_sw)
        (state_q == ST_SHOW) |-> $onehot(lamp)); // R3
    AST_GROW_ONE: assert property (@(posedge clk) disable iff (rst_sw)
        ($past(state_q) == ST_ADD && state_q != ST_TSWEEP) |-> (len_q == $past(len_q) + LEN_W'(1))); // R4
    AST_OVER_FROZEN: assert property (@(posedge clk) disable iff (rst_sw)
        ($past(state_q) == ST_OVER && state_q == ST_OVER) |-> $stable(score_q)); // R6
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst_sw)
        len_q <= LEN_W'(DEPTH)); // R9
    AST_LAMP_ONEHOT0: assert property (@(posedge clk) disable iff (rst_sw)
        $onehot0(lamp)); // R10
endmodule

// File: tb/seq_game_ctrl_tb.sv
`timescale 1ns/1ps
module seq_game_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_sw, test_sw, tick;
    logic [3:0] btn;
    logic [3:0] lamp;
    logic [6:0] seg_turn, seg_tens, seg_ones;

    localparam logic [6:0] C_DASH = 7'h3F, C_MACH = 7'h46, C_PLYR = 7'h0C,
                           C_OVER = 7'h06, C_WIN = 7'h41, C_TEST = 7'h07;

    int n_chk  = 0;
    int n_fail = 0;
    int seq [64];
    int seq_n  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    seq_game_ctrl u_dut (
        .clk (clk), .rst_sw (rst_sw), .test_sw (test_sw), .tick (tick), .btn (btn),
        .lamp (lamp), .seg_turn (seg_turn), .seg_tens (seg_tens), .seg_ones (seg_ones)
    );

    function automatic logic [6:0] dec7(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; default: return 7'h10;
        endcase
    endfunction

    function automatic int lamp_idx(input logic [3:0] l);
        case (l)
            4'b0001: return 0; 4'b0010: return 1;
            4'b0100: return 2; default: return 3;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] b);
        @(negedge clk) btn = b;
        @(negedge clk) btn = 4'b0000;
    endtask

    task automatic check_score(input string req, input int s);
        check(req, seg_tens, dec7(s / 10));
        check(req, seg_ones, dec7(s % 10));
    endtask

    // learn one playback from the lamps; optional timing, last-gap press, tick stall
    task automatic watch(input int exp_n, input bit timing, input bit inject, input bit hold);
        int steps = 0, run = 0, gap = 0, guard = 0, bad = 0;
        logic [3:0] prev = 4'b0000;
        int got [64];
        while (1) begin
            @(negedge clk);
            btn = 4'b0000;
            guard++;
            if (seg_turn == C_PLYR || guard > 2000) break;
            if (lamp != 4'b0000) begin
                if (prev == 4'b0000) begin
                    if (timing && steps > 0) check("R3 gap length", gap, 4);
                    if (steps < 64) got[steps] = lamp_idx(lamp);
                    steps++;
                    run = 0;
                    check("R3 one lamp lit", $countones(lamp), 1);
                    check("R8 machine turn code", seg_turn, C_MACH);
                end
                run++;
                if (hold && steps == 1 && run == 1) begin
                    tick = 1'b0;
                    for (int k = 0; k < 40; k++) begin
                        @(negedge clk);
                        if (lamp != prev && prev != 0) bad++;
                        if (lamp != 4'b0000 && k == 0) prev = lamp;
                    end
                    check("R3 stalled tick holds lamp", bad, 0);
                    tick = 1'b1;
                end
            end else begin
                if (prev != 4'b0000) begin
                    if (timing) check("R3 lit length", run, 8);
                    gap = 0;
                end
                if (steps > 0) gap++;
                if (inject && steps == exp_n && gap == 4) btn = 4'b1000;
            end
            prev = lamp;
        end
        check("R5 reached entry phase", seg_turn, C_PLYR);
        if (timing) check("R3 final gap length", gap, 4);
        check("R4 pattern length", steps, exp_n);
        bad = 0;
        for (int i = 0; i < seq_n && i < steps; i++) if (got[i] != seq[i]) bad++;
        check("R4 earlier steps kept", bad, 0);
        for (int i = 0; i < steps && i < 64; i++) seq[i] = got[i];
        seq_n = steps;
    endtask

    task automatic enter_all();
        for (int i = 0; i < seq_n; i++) begin
            press(4'b0001 << seq[i]);
            if (i < seq_n - 1) check("R5 correct press keeps entry", seg_turn, C_PLYR);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_sw = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 lamps off in reset", lamp, 0);
        check("R1 dash in reset", seg_turn, C_DASH);
        rst_sw = 1'b0;
        @(negedge clk);
        check("R1 lamps off after reset", lamp, 0);
        check("R1 dash after reset", seg_turn, C_DASH);
        check_score("R1 zero score", 0);
        seq_n = 0;
    endtask

    task automatic t_selftest();
        int bad = 0;
        @(negedge clk) test_sw = 1'b1;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (lamp != (4'b0001 << (k / 8))) bad++;
            if (seg_turn != C_TEST || seg_tens != C_TEST || seg_ones != C_TEST) bad++;
        end
        check("R10 sweep order and digits", bad, 0);
        @(negedge clk);
        check("R10 dark after sweep", lamp, 0);
        press(4'b0100);
        check("R10 echo lamp 2", lamp, 4'b0100);
        press(4'b0011);
        check("R10 multi press ignored", lamp, 4'b0100);
        press(4'b0001);
        check("R10 echo lamp 0", lamp, 4'b0001);
        check("R10 test code", seg_ones, C_TEST);
        test_sw = 1'b0;
        @(negedge clk);
        check("R10 back to idle", seg_turn, C_DASH);
        check("R10 lamps off in idle", lamp, 0);
    endtask

    task automatic t_game();
        press(4'b0010);
        check("R2 start shows machine turn", seg_turn, C_MACH);
        watch(1, 1, 0, 1);
        enter_all();
        check_score("R7 score one", 1);
        check("R8 next round machine turn", seg_turn, C_MACH);
        watch(2, 1, 1, 0);
        enter_all();
        check_score("R5 last-gap press ignored, score two", 2);
        watch(3, 1, 0, 0);
        press(4'b0001 << ((seq[0] + 1) % 4));
        check("R6 wrong press over code", seg_turn, C_OVER);
        check("R6 lamps dark", lamp, 0);
        check_score("R6 score frozen", 2);
        press(4'b0001 << seq[0]);
        press(4'b1111);
        check("R6 later presses ignored", seg_turn, C_OVER);
        check_score("R6 score still frozen", 2);
    endtask

    task automatic t_multi();
        do_reset();
        press(4'b0001);
        watch(1, 1, 0, 0);
        check("R1 new game after reset has one step", seq_n, 1);
        press((4'b0001 << seq[0]) | (4'b0001 << ((seq[0] + 2) % 4)));
        check("R6 two buttons end game", seg_turn, C_OVER);
        check_score("R6 score zero", 0);
    endtask

    task automatic t_win();
        do_reset();
        press(4'b0100);
        for (int r = 1; r <= 32; r++) begin
            watch(r, 0, 0, 0);
            enter_all();
        end
        check("R9 win code", seg_turn, C_WIN);
        check_score("R9 score 32", 32);
        check("R7 tens digit three", seg_tens, 7'h30);
        press(4'b0001);
        check("R9 press after win ignored", seg_turn, C_WIN);
        check_score("R9 score kept", 32);
        check("R9 lamps dark", lamp, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_sw = 1'b1; test_sw = 1'b0; tick = 1'b1; btn = 4'b0000;
        do_reset();
        t_selftest();
        t_game();
        t_multi();
        t_win();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule